// File: doc/BRIEF.md
# Byte-Written Output Compare Unit

This block holds a 16-bit compare value that software loads over an 8-bit register bus, one byte at a time. It watches a free-running count supplied from outside. On each cycle in which that count advances, the block compares the count with the stored value. When they are equal, it sets a sticky compare flag and copies a software-chosen level bit into a registered output pin. It also raises an interrupt request when that request is enabled.

Loading the value takes two separate bus writes. A write to the high byte therefore suspends matching until the low byte has also been written, so a half-updated value can never produce a false match. A write to the low byte alone leaves matching active. Software clears the flag in two steps: it reads status while the flag is set, then writes the low byte. The compare bytes are plain storage. Reset does not touch them and the hardware never modifies them, so they can serve as scratch bytes when compare is unused.

Top module: `out_compare_unit`

## Requirements
- R1: Bus address 0 holds the compare high byte and address 1 the low byte. A write to one byte leaves the other byte unchanged. Reading either address returns the last value written to it.
- R2: Reset leaves the compare bytes unchanged. It clears the flag, the output pin, the suspend state and both control bits.
- R3: The flag is status bit 0 (address 3). It is set on the clock edge that ends a cycle in which `countTick` is high, `countIn` equals the compare value, and matching is not suspended.
- R4: Each such match loads the level bit into `cmpOut` on the same edge, whether the flag was already set or clear. The level bit is control bit 0 (address 2).
- R5: While `countTick` is low, an equal count causes no match: the flag and `cmpOut` keep their values.
- R6: A high-byte write suspends matching. The suspension continues through the cycle of the next low-byte write and ends after that write.
- R7: A low-byte write that is not preceded by a high-byte write leaves matching active.
- R8: The flag clears on a low-byte write only if status was read while the flag was set, earlier than that write. A low-byte write without such a read leaves the flag set.
- R9: If a match occurs in the same cycle as the clearing low-byte write, the flag stays set.
- R10: `irq` is high exactly when the flag is set and the interrupt enable is set. The interrupt enable is control bit 1.
- R11: Writes to the status address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (only the status read has a side effect) |
| addr | input | 2 | Register select: 0 high byte, 1 low byte, 2 control, 3 status |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| countIn | input | 16 | Free-running count value |
| countTick | input | 1 | High in the cycle in which `countIn` has just advanced |
| cmpOut | output | 1 | Registered compare output level |
| irq | output | 1 | Compare interrupt request |

## Verification
The bench probes several corner cases:
- A match that falls between a high-byte and a low-byte write, and a match in the very cycle of the closing low-byte write. A design that resumes compare too early would set the flag in one of those cases.
- A low-byte write alone. A design that suspends compare on any write would miss the match that follows.
- A match while the flag is already set, with the level bit changed. A design that loads the pin only on the flag's rising edge would keep the stale level.
- Clearing the flag with and without the preceding status read, and clearing in the same cycle as a match. A design that drops the read condition, or lets the clear win over the match, would lose the flag.
- A reset between writing and reading the compare bytes, which exposes any reset applied to the storage.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

  typedef enum logic [1:0] {
    REG_CMP_HI = 2'd0,
    REG_CMP_LO = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STATUS = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrHi;
    logic wrLo;
    logic loadLevel;
  } dpStrobe_t;

endpackage

// File: rtl/ocu_datapath.sv
module ocu_datapath
  import ocu_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [BUS_W-1:0] wrData,
  input  logic [CNT_W-1:0] countIn,
  input  logic             countTick,
  input  logic             levelBit,
  output logic             hit,
  output logic [CNT_W-1:0] cmpVal,
  output logic             cmpOut
);

  logic [1:0] laneWr;
  assign laneWr = {strb.wrHi, strb.wrLo};

  // compare storage: one lane per byte, deliberately not reset
  for (genvar lane = 0; lane < 2; lane++) begin : gLane
    logic [BUS_W-1:0] laneQ;
    always_ff @(posedge clk) begin
      if (laneWr[lane]) laneQ <= wrData;
    end
    assign cmpVal[lane*BUS_W +: BUS_W] = laneQ;
  end

  assign hit = countTick && (countIn == cmpVal);

  always_ff @(posedge clk) begin
    if (!rstN)               cmpOut <= 1'b0;
    else if (strb.loadLevel) cmpOut <= levelBit;
  end

endmodule

// File: rtl/ocu_ctrl.sv
module ocu_ctrl
  import ocu_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [1:0]       addr,
  input  logic [1:0]       wrBits,
  input  logic             hit,
  input  logic [CNT_W-1:0] cmpVal,
  output dpStrobe_t        strb,
  output logic             inhibit,
  output logic             ocfFlag,
  output logic             levelBit,
  output logic             ieBit,
  output logic             irq,
  output logic [BUS_W-1:0] rdData
);

  logic wrHi, wrLo, wrCtrl, rdStatus, matchNow, clearArm, doClear;

  assign wrHi     = wrEn && (addr == REG_CMP_HI);
  assign wrLo     = wrEn && (addr == REG_CMP_LO);
  assign wrCtrl   = wrEn && (addr == REG_CTRL);
  assign rdStatus = rdEn && (addr == REG_STATUS);
  assign matchNow = hit && !inhibit;
  assign doClear  = wrLo && clearArm;

  assign strb.wrHi      = wrHi;
  assign strb.wrLo      = wrLo;
  assign strb.loadLevel = matchNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inhibit  <= 1'b0;
      ocfFlag  <= 1'b0;
      clearArm <= 1'b0;
      levelBit <= 1'b0;
      ieBit    <= 1'b0;
    end else begin
      if (wrHi)      inhibit <= 1'b1;
      else if (wrLo) inhibit <= 1'b0;

      if (wrCtrl) begin
        levelBit <= wrBits[0];
        ieBit    <= wrBits[1];
      end

      if (matchNow)     ocfFlag <= 1'b1;
      else if (doClear) ocfFlag <= 1'b0;

      if (doClear)                 clearArm <= 1'b0;
      else if (rdStatus && ocfFlag) clearArm <= 1'b1;
    end
  end

  assign irq = ocfFlag && ieBit;

  always_comb begin
    rdData = '0;
    unique case (addr)
      REG_CMP_HI: rdData = cmpVal[CNT_W-1:BUS_W];
      REG_CMP_LO: rdData = cmpVal[BUS_W-1:0];
      REG_CTRL:   rdData = {{(BUS_W-2){1'b0}}, ieBit, levelBit};
      REG_STATUS: rdData = {{(BUS_W-1){1'b0}}, ocfFlag};
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/out_compare_unit.sv
module out_compare_unit
  import ocu_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wrData,
  output logic [BUS_W-1:0] rdData,
  input  logic [CNT_W-1:0] countIn,
  input  logic             countTick,
  output logic             cmpOut,
  output logic             irq
);

  dpStrobe_t        strb;
  logic             hit, inhibit, ocfFlag, levelBit, ieBit;
  logic [CNT_W-1:0] cmpVal;
  logic [BUS_W-3:0] wrSpare;

  assign wrSpare = wrData[BUS_W-1:2];

  ocu_ctrl #(.BUS_W(BUS_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrBits(wrData[1:0]), .hit(hit), .cmpVal(cmpVal), .strb(strb),
    .inhibit(inhibit), .ocfFlag(ocfFlag), .levelBit(levelBit),
    .ieBit(ieBit), .irq(irq), .rdData(rdData)
  );

  ocu_datapath #(.BUS_W(BUS_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .countIn(countIn), .countTick(countTick), .levelBit(levelBit),
    .hit(hit), .cmpVal(cmpVal), .cmpOut(cmpOut)
  );

endmodule

// File: rtl/ocu_checker.sv
module ocu_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] countIn,
  input logic             countTick,
  input logic [CNT_W-1:0] cmpVal,
  input logic             inhibit,
  input logic             ocfFlag,
  input logic             levelBit,
  input logic             ieBit,
  input logic             cmpOut,
  input logic             irq
);

  AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (countTick && countIn == cmpVal && !inhibit) |=> ocfFlag); // R3

  AST_LEVEL_TO_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (countTick && countIn == cmpVal && !inhibit) |=> (cmpOut == $past(levelBit))); // R4

  AST_NO_TICK_HOLDS_PIN: assert property (@(posedge clk) disable iff (!rstN)
    !countTick |=> $stable(cmpOut)); // R5

  AST_HI_WRITE_SUSPENDS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd0) |=> inhibit); // R6

  AST_SUSPENDED_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (inhibit && !ocfFlag) |=> !ocfFlag); // R6

  AST_LO_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (!inhibit && !(wrEn && addr == 2'd0)) |=> !inhibit); // R7

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !ieBit |-> !irq); // R10

endmodule

bind out_compare_unit ocu_checker #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .countIn(countIn),
  .countTick(countTick), .cmpVal(cmpVal), .inhibit(inhibit),
  .ocfFlag(ocfFlag), .levelBit(levelBit), .ieBit(ieBit),
  .cmpOut(cmpOut), .irq(irq)
);

// File: tb/test_out_compare_unit.sv
module test_out_compare_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wrData = 8'd0;
  logic [7:0]  rdData;
  logic [15:0] countIn = 16'd0;
  logic        countTick = 1'b0;
  logic        cmpOut;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  out_compare_unit i_out_compare_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .countIn(countIn),
    .countTick(countTick), .cmpOut(cmpOut), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdData;
  endtask

  task automatic tick(input logic [15:0] v);
    @(negedge clk); countIn = v; countTick = 1'b1;
    @(negedge clk); countTick = 1'b0;
  endtask

  task automatic clearFlag();
    logic [7:0] s, lo;
    peek(2'd1, lo);
    busRead(2'd3, s);
    busWrite(2'd1, lo);
  endtask

  task automatic testReset();
    logic [7:0] d;
    peek(2'd3, d); check("R2 flag after reset", d, 0);
    peek(2'd2, d); check("R2 control after reset", d, 0);
    check("R2 pin after reset", cmpOut, 0);
    check("R2 irq after reset", irq, 0);
  endtask

  task automatic testStorage();
    logic [7:0] d;
    busWrite(2'd0, 8'h12); busWrite(2'd1, 8'h34);
    peek(2'd0, d); check("R1 high readback", d, 8'h12);
    peek(2'd1, d); check("R1 low readback", d, 8'h34);
    busWrite(2'd0, 8'hAB);
    peek(2'd1, d); check("R1 low kept after high write", d, 8'h34);
    peek(2'd0, d); check("R1 high new value", d, 8'hAB);
    busWrite(2'd1, 8'h34);
    busWrite(2'd3, 8'hFF);
    peek(2'd3, d); check("R11 status write ignored", d, 0);
  endtask

  task automatic testMatch();
    logic [7:0] d;
    busWrite(2'd2, 8'h01);
    @(negedge clk); countIn = 16'hAB34;
    repeat (3) @(negedge clk);
    peek(2'd3, d); check("R5 no match without tick", d, 0);
    check("R5 pin held without tick", cmpOut, 0);
    tick(16'hAB35);
    peek(2'd3, d); check("R3 unequal tick no flag", d, 0);
    tick(16'hAB34);
    peek(2'd3, d); check("R3 match sets flag", d, 1);
    check("R4 level loaded", cmpOut, 1);
    busWrite(2'd2, 8'h00);
    tick(16'hAB34);
    check("R4 level loaded with flag set", cmpOut, 0);
    peek(2'd3, d); check("R4 flag stays", d, 1);
  endtask

  task automatic testClear();
    logic [7:0] d;
    busWrite(2'd1, 8'h34);
    peek(2'd3, d); check("R8 no clear without read", d, 1);
    busRead(2'd3, d);
    busWrite(2'd1, 8'h34);
    peek(2'd3, d); check("R8 clear after read and write", d, 0);
  endtask

  task automatic testIrq();
    logic [7:0] d;
    busWrite(2'd2, 8'h02);
    check("R10 irq low with flag clear", irq, 0);
    tick(16'hAB34);
    check("R10 irq with flag and enable", irq, 1);
    busWrite(2'd2, 8'h00);
    check("R10 irq gated off", irq, 0);
    clearFlag();
    peek(2'd3, d); check("R10 flag cleared", d, 0);
  endtask

  task automatic testSuspend();
    logic [7:0] d;
    busWrite(2'd2, 8'h01);
    busWrite(2'd0, 8'hAB);
    tick(16'hAB34);
    peek(2'd3, d); check("R6 suspended after high write", d, 0);
    check("R6 pin unchanged while suspended", cmpOut, 0);
    @(negedge clk); wrEn = 1'b1; addr = 2'd1; wrData = 8'h34;
    countIn = 16'hAB34; countTick = 1'b1;
    @(negedge clk); wrEn = 1'b0; countTick = 1'b0;
    peek(2'd3, d); check("R6 still suspended during low write", d, 0);
    tick(16'hAB34);
    peek(2'd3, d); check("R6 resumed after low write", d, 1);
    check("R6 pin after resume", cmpOut, 1);
  endtask

  task automatic testLowOnly();
    logic [7:0] d;
    clearFlag();
    busWrite(2'd1, 8'h40);
    tick(16'hAB40);
    peek(2'd3, d); check("R7 low write keeps compare", d, 1);
  endtask

  task automatic testClearRace();
    logic [7:0] d;
    busRead(2'd3, d);
    @(negedge clk); wrEn = 1'b1; addr = 2'd1; wrData = 8'h40;
    countIn = 16'hAB40; countTick = 1'b1;
    @(negedge clk); wrEn = 1'b0; countTick = 1'b0;
    peek(2'd3, d); check("R9 match beats clear", d, 1);
  endtask

  task automatic testResetKeeps();
    logic [7:0] d;
    busWrite(2'd0, 8'h5A); busWrite(2'd1, 8'hC3);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    peek(2'd0, d); check("R2 high kept over reset", d, 8'h5A);
    peek(2'd1, d); check("R2 low kept over reset", d, 8'hC3);
    peek(2'd3, d); check("R2 flag cleared by reset", d, 0);
    check("R2 pin cleared by reset", cmpOut, 0);
    tick(16'h5AC3);
    peek(2'd3, d); check("R2 not suspended after reset", d, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStorage();
    testMatch();
    testClear();
    testIrq();
    testSuspend();
    testLowOnly();
    testClearRace();
    testResetKeeps();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule